// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is a single down-counting interval timer channel. It advances on an input tick enable rather than on every clock. A load strobe captures a reload value and a mode code together and restarts the channel. The mode code selects one of six output waveforms: a terminal-count flag, a retriggerable one-shot, a rate generator, a square wave, a software strobe and a hardware strobe. A reload value of zero stands for the full 2^CNT_W-tick period.

The channel tracks elapsed ticks since the last restart. The output level, the live count and a maskable interrupt line are all derived from that tick count. A rising edge on the gate input restarts counting in the modes that are gate-triggered. In the other modes the gate level is only recorded. The mask input forces the interrupt line inactive while counting carries on.

Top module: `pit_channel`

## Requirements
- R1: A reload value of zero gives a period of 2^CNT_W (65536) ticks. After reset, in square-wave mode, the output stays high for the first 32768 ticks and goes low on tick 32768.
- R2: A load strobe takes reload_val and mode_sel and sets the elapsed-tick count to zero. On the next edge, live_count equals reload_val. This holds even if tick_en is high in the same cycle.
- R3: Mode 0 (terminal-count flag): out_level is low while elapsed < period. It is high from elapsed == period onward and stays high.
- R4: Mode 1 (one-shot): out_level is high while elapsed < period and low afterwards.
- R5: Mode 2 (rate generator): out_level is high for exactly one tick each time elapsed reaches a nonzero multiple of the period. It is low otherwise.
- R6: Mode 3 (square wave): within each period, out_level is high for the first (period+1)/2 ticks and low for the rest.
- R7: Modes 4 and 5 (strobes): out_level is high only while elapsed equals the period, which lasts a single tick.
- R8: A rising gate_in edge restarts the elapsed count to zero in modes 1, 2, 3 and 5. In modes 0 and 4 the edge has no effect on count or output.
- R9: Reset gives mode 3, a 65536-tick period, out_level high, live_count 0 and irq_out low. The recorded gate level resets high unless CHAN_ID equals GATE_LOW_CHAN. So on channel 0, a gate held high through reset release does not restart counting.
- R10: While irq_mask is high, irq_out is low. While irq_mask is low, irq_out equals out_level, and releasing the mask brings irq_out to out_level on the next edge.
- R11: Mode codes 6 and 7 behave as modes 2 and 3.
- R12: live_count equals the period minus the elapsed ticks, modulo 2^CNT_W. In modes 2 and 3 the elapsed count wraps to zero at the period. When tick_en is low, no tick is counted and the outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counting tick enable |
| gate_in | input | 1 | Gate level, rising edge retriggers some modes |
| reload_val | input | CNT_W | Reload value, zero means full period |
| mode_sel | input | 3 | Mode code taken with the load strobe |
| load_stb | input | 1 | Load reload value and mode, restart count |
| irq_mask | input | 1 | Forces irq_out inactive |
| out_level | output | 1 | Channel output waveform |
| irq_out | output | 1 | Masked copy of the output |
| live_count | output | CNT_W | Current count for readback |

## Verification
All three outputs are registered from the next-state values. Their response to a load strobe, a tick, a gate edge or a mask change therefore appears right after the same clock edge that samples that input. The bench changes inputs on the falling edge and samples outputs on the following falling edge. Each expected value is worked out from the number of rising edges that have passed since the last load strobe. A gate pulse costs two edges, one low and one high, and both count as ticks when tick_en is high.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [2:0] {
    PM_TERM     = 3'd0,
    PM_ONESHOT  = 3'd1,
    PM_RATE     = 3'd2,
    PM_SQUARE   = 3'd3,
    PM_SWSTROBE = 3'd4,
    PM_HWSTROBE = 3'd5
  } pit_mode_e;

endpackage

// File: rtl/pit_mode_decode.sv
module pit_mode_decode
  import pit_pkg::*;
(
  input  logic [2:0] code,
  output pit_mode_e  mode,
  output logic       periodic,
  output logic       gate_retrig
);

  always_comb begin
    unique case (code)
      3'd0:    mode = PM_TERM;
      3'd1:    mode = PM_ONESHOT;
      3'd2:    mode = PM_RATE;
      3'd3:    mode = PM_SQUARE;
      3'd4:    mode = PM_SWSTROBE;
      3'd5:    mode = PM_HWSTROBE;
      3'd6:    mode = PM_RATE;
      3'd7:    mode = PM_SQUARE;
      default: mode = PM_TERM;
    endcase
  end

  always_comb begin
    periodic    = (mode == PM_RATE) || (mode == PM_SQUARE);
    gate_retrig = (mode == PM_ONESHOT) || (mode == PM_RATE) ||
                  (mode == PM_SQUARE)  || (mode == PM_HWSTROBE);
  end

endmodule

// File: rtl/pit_phase_counter.sv
module pit_phase_counter #(
  parameter int PH_W = 17
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic            tick,
  input  logic            periodic,
  input  logic [PH_W-1:0] period,
  output logic [PH_W-1:0] phase_q,
  output logic [PH_W-1:0] phase_nx,
  output logic            wrap_nx
);

  logic wrap_q;

  always_comb begin
    phase_nx = phase_q;
    wrap_nx  = wrap_q;
    if (restart) begin
      phase_nx = '0;
      wrap_nx  = 1'b0;
    end else if (tick) begin
      if (periodic) begin
        if (phase_q >= period - 1'b1) begin
          phase_nx = '0;
          wrap_nx  = 1'b1;
        end else begin
          phase_nx = phase_q + 1'b1;
        end
      end else if (phase_q <= period) begin
        phase_nx = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      wrap_q  <= 1'b0;
    end else begin
      phase_q <= phase_nx;
      wrap_q  <= wrap_nx;
    end
  end

endmodule

// File: rtl/pit_wave_gen.sv
module pit_wave_gen
  import pit_pkg::*;
#(
  parameter int PH_W = 17
) (
  input  pit_mode_e       mode,
  input  logic [PH_W-1:0] period,
  input  logic [PH_W-1:0] phase,
  input  logic            wrapped,
  output logic            level
);

  logic [PH_W:0]   half_sum;
  logic [PH_W-1:0] half_len;

  always_comb begin
    half_sum = {1'b0, period} + 1'b1;
    half_len = half_sum[PH_W:1];
  end

  always_comb begin
    unique case (mode)
      PM_TERM:     level = (phase >= period);
      PM_ONESHOT:  level = (phase < period);
      PM_RATE:     level = (phase == '0) && wrapped;
      PM_SQUARE:   level = (phase < half_len);
      PM_SWSTROBE,
      PM_HWSTROBE: level = (phase == period);
      default:     level = (phase >= period);
    endcase
  end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter int CHAN_ID       = 0,
  parameter int GATE_LOW_CHAN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             gate_in,
  input  logic [CNT_W-1:0] reload_val,
  input  logic [2:0]       mode_sel,
  input  logic             load_stb,
  input  logic             irq_mask,
  output logic             out_level,
  output logic             irq_out,
  output logic [CNT_W-1:0] live_count
);

  localparam int              PH_W        = CNT_W + 1;
  localparam logic [PH_W-1:0] FULL_PERIOD = PH_W'(1) << CNT_W;
  localparam logic            GATE_RST    = (CHAN_ID != GATE_LOW_CHAN);

  pit_mode_e       mode_q, mode_nx, mode_new, mode_cur;
  logic [PH_W-1:0] period_q, period_nx;
  logic            gate_q;
  logic            per_new, per_cur, retrig_new, retrig_cur;
  logic            restart;
  logic [PH_W-1:0] phase_q, phase_nx;
  logic            wrap_nx;
  logic            out_nx;

  pit_mode_decode u_dec_new (
    .code       (mode_sel),
    .mode       (mode_new),
    .periodic   (per_new),
    .gate_retrig(retrig_new)
  );

  pit_mode_decode u_dec_cur (
    .code       (mode_q),
    .mode       (mode_cur),
    .periodic   (per_cur),
    .gate_retrig(retrig_cur)
  );

  always_comb begin
    if (load_stb) begin
      mode_nx   = mode_new;
      period_nx = (reload_val == '0) ? FULL_PERIOD : {1'b0, reload_val};
    end else begin
      mode_nx   = mode_cur;
      period_nx = period_q;
    end
    restart = load_stb || (retrig_cur && gate_in && !gate_q);
  end

  pit_phase_counter #(.PH_W(PH_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (tick_en),
    .periodic(load_stb ? per_new : per_cur),
    .period  (period_nx),
    .phase_q (phase_q),
    .phase_nx(phase_nx),
    .wrap_nx (wrap_nx)
  );

  pit_wave_gen #(.PH_W(PH_W)) u_wave (
    .mode   (mode_nx),
    .period (period_nx),
    .phase  (phase_nx),
    .wrapped(wrap_nx),
    .level  (out_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= PM_SQUARE;
      period_q   <= FULL_PERIOD;
      gate_q     <= GATE_RST;
      out_level  <= 1'b1;
      irq_out    <= 1'b0;
      live_count <= '0;
    end else begin
      mode_q     <= mode_nx;
      period_q   <= period_nx;
      gate_q     <= gate_in;
      out_level  <= out_nx;
      irq_out    <= out_nx && !irq_mask;
      live_count <= CNT_W'(period_nx - phase_nx);
    end
  end

endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             gate_in,
  input logic [CNT_W-1:0] reload_val,
  input logic             load_stb,
  input logic             irq_mask,
  input logic             out_level,
  input logic             irq_out,
  input logic [CNT_W-1:0] live_count,
  input logic [2:0]       mode_q,
  input logic [CNT_W:0]   period_q,
  input logic [CNT_W:0]   phase_q
);

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> (live_count == $past(reload_val)));

  assert_mask_R10: assert property (@(posedge clk) disable iff (rst)
    irq_mask |=> !irq_out);

  assert_follow_R10: assert property (@(posedge clk) disable iff (rst)
    !irq_mask |=> (irq_out == out_level));

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!load_stb && !tick_en && !gate_in) |=> ($stable(live_count) && $stable(out_level)));

  assert_range_R12: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == 3'd2) || (mode_q == 3'd3)) |-> (phase_q < period_q));

  assert_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    (((mode_q == 3'd4) || (mode_q == 3'd5)) && out_level && tick_en && !load_stb)
      |=> !out_level);

  assert_rate_R5: assert property (@(posedge clk) disable iff (rst)
    ((mode_q == 3'd2) && out_level && (period_q > 1) && tick_en && !load_stb)
      |=> !out_level);

endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .gate_in   (gate_in),
  .reload_val(reload_val),
  .load_stb  (load_stb),
  .irq_mask  (irq_mask),
  .out_level (out_level),
  .irq_out   (irq_out),
  .live_count(live_count),
  .mode_q    (mode_q),
  .period_q  (period_q),
  .phase_q   (phase_q)
);

// File: tb/pit_channel_tb.sv
module pit_channel_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_en = 1'b0;
  logic        gate_in = 1'b1;
  logic [15:0] reload_val = '0;
  logic [2:0]  mode_sel = 3'd0;
  logic        load_stb = 1'b0;
  logic        irq_mask = 1'b0;
  logic        out_level, irq_out;
  logic [15:0] live_count;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  pit_channel u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .gate_in(gate_in),
    .reload_val(reload_val), .mode_sel(mode_sel), .load_stb(load_stb),
    .irq_mask(irq_mask), .out_level(out_level), .irq_out(irq_out),
    .live_count(live_count)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(int val, int code);
    reload_val = 16'(val);
    mode_sel   = 3'(code);
    load_stb   = 1'b1;
    @(negedge clk);
    load_stb   = 1'b0;
  endtask

  task automatic gate_pulse();
    gate_in = 1'b0;
    step(1);
    gate_in = 1'b1;
    step(1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R9", "reset out", out_level, 1);
    chk("R9", "reset count", live_count, 0);
    chk("R9", "reset irq", irq_out, 0);
    tick_en = 1'b1;
    step(2);
    chk("R9", "gate held high, no restart", live_count, 65534);
    chk("R10", "irq follows out", irq_out, 1);
  endtask

  task automatic t_zero_reload();
    step(32765);
    chk("R1", "high before half", out_level, 1);
    chk("R1", "count at 32767", live_count, 32769);
    step(1);
    chk("R1", "low at half", out_level, 0);
    chk("R1", "count at half", live_count, 32768);
  endtask

  task automatic t_mode0();
    load(4, 0);
    chk("R2", "load count", live_count, 4);
    chk("R3", "low after load", out_level, 0);
    step(3);
    chk("R3", "low before tc", out_level, 0);
    step(1);
    chk("R3", "high at tc", out_level, 1);
    chk("R12", "count at tc", live_count, 0);
    step(3);
    chk("R3", "stays high", out_level, 1);
    chk("R12", "count past tc", live_count, 65535);
    gate_pulse();
    chk("R8", "mode0 gate ignored count", live_count, 65535);
    chk("R8", "mode0 gate ignored out", out_level, 1);
  endtask

  task automatic t_mode1();
    load(3, 1);
    chk("R4", "high after load", out_level, 1);
    step(2);
    chk("R4", "high before end", out_level, 1);
    step(1);
    chk("R4", "low at end", out_level, 0);
    gate_pulse();
    chk("R8", "mode1 retrigger out", out_level, 1);
    chk("R8", "mode1 retrigger count", live_count, 3);
  endtask

  task automatic t_mode2();
    load(3, 2);
    chk("R5", "low after load", out_level, 0);
    step(2);
    chk("R5", "low at 2", out_level, 0);
    step(1);
    chk("R5", "pulse at 3", out_level, 1);
    chk("R12", "wrap count", live_count, 3);
    step(1);
    chk("R5", "low after pulse", out_level, 0);
    chk("R12", "count after wrap", live_count, 2);
    step(2);
    chk("R5", "pulse at 6", out_level, 1);
    gate_pulse();
    chk("R8", "mode2 retrigger count", live_count, 3);
  endtask

  task automatic t_mode3();
    load(5, 3);
    chk("R6", "high at 0", out_level, 1);
    step(2);
    chk("R6", "high at 2", out_level, 1);
    step(1);
    chk("R6", "low at 3", out_level, 0);
    step(1);
    chk("R6", "low at 4", out_level, 0);
    step(1);
    chk("R6", "high at wrap", out_level, 1);
    chk("R12", "count at wrap", live_count, 5);
  endtask

  task automatic t_strobes();
    load(2, 4);
    step(1);
    chk("R7", "mode4 low at 1", out_level, 0);
    step(1);
    chk("R7", "mode4 high at 2", out_level, 1);
    step(1);
    chk("R7", "mode4 low at 3", out_level, 0);
    step(5);
    chk("R7", "mode4 stays low", out_level, 0);
    gate_pulse();
    chk("R8", "mode4 gate ignored", live_count, 65535);
    load(2, 5);
    step(3);
    chk("R7", "mode5 low after", out_level, 0);
    gate_pulse();
    chk("R8", "mode5 retrigger count", live_count, 2);
    step(2);
    chk("R7", "mode5 strobe", out_level, 1);
  endtask

  task automatic t_alias();
    load(3, 6);
    step(3);
    chk("R11", "code6 pulse", out_level, 1);
    load(4, 7);
    step(1);
    chk("R11", "code7 high at 1", out_level, 1);
    step(1);
    chk("R11", "code7 low at 2", out_level, 0);
    chk("R12", "code7 count", live_count, 2);
  endtask

  task automatic t_hold();
    tick_en = 1'b0;
    step(5);
    chk("R12", "hold count", live_count, 2);
    chk("R12", "hold out", out_level, 0);
    tick_en = 1'b1;
    load(9, 3);
    chk("R2", "load with tick", live_count, 9);
  endtask

  task automatic t_mask();
    irq_mask = 1'b1;
    load(2, 0);
    step(3);
    chk("R10", "out while masked", out_level, 1);
    chk("R10", "irq masked", irq_out, 0);
    irq_mask = 1'b0;
    step(1);
    chk("R10", "irq after release", irq_out, 1);
  endtask

  initial begin
    t_reset();
    t_zero_reload();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_strobes();
    t_alias();
    t_hold();
    t_mask();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule